// File: doc/BRIEF.md
# Split-Output Vectored Interrupt Controller

This block gathers 64 level-driven interrupt sources and routes each one either to a fast request line or to a normal request line. For every source it keeps three state bits: pending, enabled, and type (fast or normal). The fast line asserts whenever any enabled, pending source is typed fast. The normal line is gated by a 5-bit priority threshold that compares against a 4-bit priority held for each source.

Software reaches the state through a word-addressed register port. A read returns data in the same cycle, and a write takes effect at the next clock edge. There are two vector registers. Reading one of them names the winning source and clears that source's pending bit in the same access. A handler can therefore claim a source with a single read.

Top module: `intc_vec_split`

## Requirements
- R1: After reset, pending, enabled, type, control, threshold and all priority words are zero, both request outputs are low, and every defined offset reads zero except offsets 16 and 17, which read all ones.
- R2: A rising input sets that source's pending bit, and a falling input clears it, at the next edge. Offset 18 returns pending bits 63..32 and offset 19 returns bits 31..0.
- R3: A write of N to offset 2 sets enable bit N, and a write of N to offset 3 clears it. Values of 64 or more change nothing. Both offsets read zero. Offsets 4 and 5 read and write enable bits 63..32 and 31..0.
- R4: Offsets 6 and 7 hold type bits 63..32 and 31..0, where 1 means fast. The fast output is high exactly when some source is pending, enabled and typed fast.
- R5: Offset 1 keeps only the low 5 bits of a write. When it holds 0x1f, the normal output is high when any normal source is pending and enabled. Otherwise the normal output needs such a source whose priority is strictly greater than the threshold.
- R6: Offset 8+k (k = 0..7) holds the priorities of sources (7-k)*8 to (7-k)*8+7. Source (7-k)*8+j uses bits 4j+3..4j.
- R7: Reading offset 16 returns {source number in bits 31..16, priority in bits 15..0} for the pending, enabled normal source of highest priority, taking the highest number on a tie. The read clears that pending bit. With no such source the read returns all ones and clears nothing.
- R8: Reading offset 17 returns the lowest-numbered pending, enabled fast source and clears that pending bit. With no such source it returns all ones.
- R9: Writes to offsets 20 and 21 overwrite pending bits 63..32 and 31..0. Within a cycle, the written value takes precedence over a source edge.
- R10: When a vector read clears a source in the same cycle that source's input rises, the pending bit ends up cleared.
- R11: Offsets 22 and 23 read pending AND enabled AND NOT type, high and low halves. Offsets 24 and 25 read pending AND enabled AND type.
- R12: Offset 0 keeps only bits 24, 22, 21, 20, 19 and 18 of a write.
- R13: Writes to offsets 16 to 19, 22 to 25 and any undefined offset change no state. Reads of undefined offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Interrupt source levels |
| bus_rd | input | 1 | Read strobe; vector reads clear a source at the edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two pairs of events can land in the same edge and must resolve in a fixed order.

- **Claim versus rising edge.** The bench forces a pending bit while that source's input is low. It then reads the fast vector in the same cycle as the input rises. The raw-source read that follows must show the bit cleared.
- **Force versus rising edge.** A force write that clears a bit is issued in the same cycle as that source's input rises. The bit must stay cleared.

A behavioural reference model checks both outcomes, together with both request outputs and the read data, on every clock.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam logic [31:0] OFS_CTRL     = 32'd0;
   localparam logic [31:0] OFS_MASK     = 32'd1;
   localparam logic [31:0] OFS_ENNUM    = 32'd2;
   localparam logic [31:0] OFS_DISNUM   = 32'd3;
   localparam logic [31:0] OFS_EN_HI    = 32'd4;
   localparam logic [31:0] OFS_EN_LO    = 32'd5;
   localparam logic [31:0] OFS_TY_HI    = 32'd6;
   localparam logic [31:0] OFS_TY_LO    = 32'd7;
   localparam logic [31:0] OFS_PRI_FRST = 32'd8;
   localparam logic [31:0] OFS_PRI_LAST = 32'd15;
   localparam logic [31:0] OFS_NVEC     = 32'd16;
   localparam logic [31:0] OFS_FVEC     = 32'd17;
   localparam logic [31:0] OFS_RAW_HI   = 32'd18;
   localparam logic [31:0] OFS_RAW_LO   = 32'd19;
   localparam logic [31:0] OFS_FRC_HI   = 32'd20;
   localparam logic [31:0] OFS_FRC_LO   = 32'd21;
   localparam logic [31:0] OFS_NPND_HI  = 32'd22;
   localparam logic [31:0] OFS_NPND_LO  = 32'd23;
   localparam logic [31:0] OFS_FPND_HI  = 32'd24;
   localparam logic [31:0] OFS_FPND_LO  = 32'd25;
   // control bits kept: 24, 22, 21, 20, 19, 18
   localparam logic [31:0] CTRL_KEEP    = 32'h017C_0000;
endpackage

// File: rtl/intc_pend_bank.sv
module intc_pend_bank #(
   parameter int NUM_SRC = 64,
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               frc_hi_i,
   input  logic               frc_lo_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic               clr_i,
   input  logic [IDX_W-1:0]   clr_idx_i,
   output logic [NUM_SRC-1:0] pend_o
);
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      localparam bit HI_HALF = (g >= DATA_W);
      logic src_q;
      logic frc;
      assign frc = HI_HALF ? frc_hi_i : frc_lo_i;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            src_q     <= 1'b0;
            pend_o[g] <= 1'b0;
         end else begin
            src_q <= src_i[g];
            if (clr_i && (clr_idx_i == IDX_W'(g)))
               pend_o[g] <= 1'b0;
            else if (frc)
               pend_o[g] <= wdata_i[g % DATA_W];
            else if (src_i[g] && !src_q)
               pend_o[g] <= 1'b1;
            else if (!src_i[g] && src_q)
               pend_o[g] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/intc_norm_arb.sv
module intc_norm_arb #(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   parameter int MASK_W  = 5,
   parameter int IDX_W   = 6
) (
   input  logic [NUM_SRC-1:0]        req_i,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
   input  logic [MASK_W-1:0]         mask_i,
   output logic                      hit_o,
   output logic [IDX_W-1:0]          idx_o,
   output logic [PRIO_W-1:0]         prio_o,
   output logic                      irq_o
);
   logic [NUM_SRC-1:0] above;
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
      assign above[g] = req_i[g] && (MASK_W'(prio_i[g*PRIO_W +: PRIO_W]) > mask_i);
   end
   assign irq_o = (&mask_i) ? (|req_i) : (|above);

   // ascending scan with >=: ties resolve to the highest number
   always_comb begin
      hit_o  = 1'b0;
      idx_o  = '0;
      prio_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req_i[i] && (!hit_o || (prio_i[i*PRIO_W +: PRIO_W] >= prio_o))) begin
            hit_o  = 1'b1;
            idx_o  = IDX_W'(i);
            prio_o = prio_i[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/intc_fast_pick.sv
module intc_fast_pick #(
   parameter int NUM_SRC = 64,
   parameter int IDX_W   = 6
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic               hit_o,
   output logic [IDX_W-1:0]   idx_o
);
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/intc_vec_split.sv
module intc_vec_split
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter int PRIO_W  = 4,
   parameter int MASK_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_rd,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_o,
   output logic               fiq_o
);
   localparam int IDX_W      = $clog2(NUM_SRC);
   localparam int PRIO_WORDS = NUM_SRC * PRIO_W / DATA_W;
   localparam int PW_W       = $clog2(PRIO_WORDS);

   if (DATA_W != 32) begin : g_bad_data
      $error("intc_vec_split: DATA_W must be 32");
   end
   if (NUM_SRC != 2 * DATA_W) begin : g_bad_src
      $error("intc_vec_split: NUM_SRC must be two data words");
   end
   if (DATA_W % PRIO_W != 0) begin : g_bad_prio
      $error("intc_vec_split: PRIO_W must divide DATA_W");
   end
   if (MASK_W <= PRIO_W) begin : g_bad_mask
      $error("intc_vec_split: MASK_W must exceed PRIO_W");
   end
   if (PRIO_WORDS != int'(OFS_PRI_LAST - OFS_PRI_FRST) + 1) begin : g_bad_pw
      $error("intc_vec_split: priority words do not fit the map");
   end
   if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr
      $error("intc_vec_split: ADDR_W out of range");
   end

   logic [31:0]         ofs;
   logic [DATA_W-1:0]   ctrl_q;
   logic [MASK_W-1:0]   mask_q;
   logic [NUM_SRC-1:0]  en_q;
   logic [NUM_SRC-1:0]  type_q;
   logic [DATA_W-1:0]   prio_q [PRIO_WORDS];
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic [NUM_SRC-1:0]  pend_q;
   logic [NUM_SRC-1:0]  norm_req;
   logic [NUM_SRC-1:0]  fast_req;
   logic                pri_hit;
   logic [PW_W-1:0]     pri_sel;
   logic                num_ok;
   logic [IDX_W-1:0]    num_idx;
   logic                n_hit;
   logic [IDX_W-1:0]    n_idx;
   logic [PRIO_W-1:0]   n_prio;
   logic                f_hit;
   logic [IDX_W-1:0]    f_idx;
   logic                clr_en;
   logic [IDX_W-1:0]    clr_idx;
   logic [DATA_W-1:0]   nvec_word;
   logic [DATA_W-1:0]   fvec_word;

   assign ofs     = 32'(bus_addr);
   assign pri_hit = (ofs >= OFS_PRI_FRST) && (ofs <= OFS_PRI_LAST);
   assign pri_sel = PW_W'(OFS_PRI_LAST - ofs);
   assign num_ok  = bus_wdata < DATA_W'(NUM_SRC);
   assign num_idx = bus_wdata[IDX_W-1:0];

   for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_pflat
      assign prio_flat[w*DATA_W +: DATA_W] = prio_q[w];
   end

   assign norm_req = pend_q & en_q & ~type_q;
   assign fast_req = pend_q & en_q & type_q;
   assign fiq_o    = |fast_req;

   intc_norm_arb #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W), .IDX_W(IDX_W)
   ) u_narb (
      .req_i(norm_req), .prio_i(prio_flat), .mask_i(mask_q),
      .hit_o(n_hit), .idx_o(n_idx), .prio_o(n_prio), .irq_o(irq_o)
   );

   intc_fast_pick #(
      .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
   ) u_fpick (
      .req_i(fast_req), .hit_o(f_hit), .idx_o(f_idx)
   );

   assign clr_en  = bus_rd && (((ofs == OFS_NVEC) && n_hit) || ((ofs == OFS_FVEC) && f_hit));
   assign clr_idx = (ofs == OFS_FVEC) ? f_idx : n_idx;

   intc_pend_bank #(
      .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) u_pend (
      .clk(clk), .rst_n(rst_n), .src_i(src_i),
      .frc_hi_i(bus_wr && (ofs == OFS_FRC_HI)),
      .frc_lo_i(bus_wr && (ofs == OFS_FRC_LO)),
      .wdata_i(bus_wdata), .clr_i(clr_en), .clr_idx_i(clr_idx),
      .pend_o(pend_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= '0;
         en_q   <= '0;
         type_q <= '0;
         for (int w = 0; w < PRIO_WORDS; w++) prio_q[w] <= '0;
      end else if (bus_wr) begin
         case (ofs)
            OFS_CTRL:   ctrl_q <= bus_wdata & CTRL_KEEP;
            OFS_MASK:   mask_q <= bus_wdata[MASK_W-1:0];
            OFS_ENNUM:  if (num_ok) en_q[num_idx] <= 1'b1;
            OFS_DISNUM: if (num_ok) en_q[num_idx] <= 1'b0;
            OFS_EN_HI:  en_q[DATA_W +: DATA_W]   <= bus_wdata;
            OFS_EN_LO:  en_q[0 +: DATA_W]        <= bus_wdata;
            OFS_TY_HI:  type_q[DATA_W +: DATA_W] <= bus_wdata;
            OFS_TY_LO:  type_q[0 +: DATA_W]      <= bus_wdata;
            default:    if (pri_hit) prio_q[pri_sel] <= bus_wdata;
         endcase
      end
   end

   always_comb begin
      nvec_word = '0;
      nvec_word[DATA_W/2 +: IDX_W] = n_idx;
      nvec_word[PRIO_W-1:0]        = n_prio;
      fvec_word = '0;
      fvec_word[IDX_W-1:0]         = f_idx;
   end

   always_comb begin
      bus_rdata = '0;
      if (pri_hit) begin
         bus_rdata = prio_q[pri_sel];
      end else begin
         case (ofs)
            OFS_CTRL:    bus_rdata = ctrl_q;
            OFS_MASK:    bus_rdata = DATA_W'(mask_q);
            OFS_EN_HI:   bus_rdata = en_q[DATA_W +: DATA_W];
            OFS_EN_LO:   bus_rdata = en_q[0 +: DATA_W];
            OFS_TY_HI:   bus_rdata = type_q[DATA_W +: DATA_W];
            OFS_TY_LO:   bus_rdata = type_q[0 +: DATA_W];
            OFS_NVEC:    bus_rdata = n_hit ? nvec_word : '1;
            OFS_FVEC:    bus_rdata = f_hit ? fvec_word : '1;
            OFS_RAW_HI:  bus_rdata = pend_q[DATA_W +: DATA_W];
            OFS_RAW_LO:  bus_rdata = pend_q[0 +: DATA_W];
            OFS_NPND_HI: bus_rdata = norm_req[DATA_W +: DATA_W];
            OFS_NPND_LO: bus_rdata = norm_req[0 +: DATA_W];
            OFS_FPND_HI: bus_rdata = fast_req[DATA_W +: DATA_W];
            OFS_FPND_LO: bus_rdata = fast_req[0 +: DATA_W];
            default:     bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/intc_vec_split_chk.sv
module intc_vec_split_chk #(
   parameter int NUM_SRC = 64,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter int MASK_W  = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_rd,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               irq_o,
   input logic               fiq_o,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] en,
   input logic [NUM_SRC-1:0] typ,
   input logic [MASK_W-1:0]  mask
);
   localparam int IDX_W = $clog2(NUM_SRC);
   logic any_fast, any_norm;
   assign any_fast = |(pend & en & typ);
   assign any_norm = |(pend & en & ~typ);

   AST_FIQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      !any_fast |-> !fiq_o);                                                  // R4
   AST_FIQ_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      any_fast |-> fiq_o);                                                    // R4
   AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((&mask) && any_norm) |-> irq_o);                                       // R5
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !any_norm |-> !irq_o);                                                  // R5
   AST_ENNUM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(2) && bus_wdata < DATA_W'(NUM_SRC))
      |=> en[$past(bus_wdata[IDX_W-1:0])]);                                   // R3
   AST_NUMREG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(2) || bus_addr == ADDR_W'(3)) |-> bus_rdata == '0); // R3
   AST_NVEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(16) && bus_rdata != '1)
      |=> !pend[$past(bus_rdata[DATA_W/2 +: IDX_W])]);                        // R7
   AST_FVEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(17) && bus_rdata != '1)
      |=> !pend[$past(bus_rdata[IDX_W-1:0])]);                                // R10
   AST_FVEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(17) && !any_fast) |-> bus_rdata == '1);            // R8
endmodule

bind intc_vec_split intc_vec_split_chk #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK_W(MASK_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .irq_o(irq_o), .fiq_o(fiq_o), .pend(pend_q), .en(en_q), .typ(type_q),
   .mask(mask_q)
);

// File: tb/tb_intc_vec_split.sv
`timescale 1ns/1ps
module tb_intc_vec_split;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src_i = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, fiq_o;

   always #2 clk = ~clk;

   intc_vec_split dut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .fiq_o(fiq_o)
   );

   int n_cmp = 0, n_bad = 0;
   bit [63:0] m_pend, m_en, m_ty, m_srcq, src_next;
   bit [31:0] m_ctrl;
   int        m_mask;
   int        m_pri [64];

   function automatic void pick_norm(output int idx, output int pr);
      bit [63:0] v = m_pend & m_en & ~m_ty;
      idx = -1; pr = -1;
      for (int i = 63; i >= 0; i--)
         if (v[i] && m_pri[i] > pr) begin idx = i; pr = m_pri[i]; end
   endfunction

   function automatic int pick_fast();
      bit [63:0] v = m_pend & m_en & m_ty;
      for (int i = 0; i < 64; i++) if (v[i]) return i;
      return -1;
   endfunction

   function automatic bit [31:0] m_read(int a);
      bit [63:0] nv = m_pend & m_en & ~m_ty;
      bit [63:0] fv = m_pend & m_en & m_ty;
      bit [31:0] r = 0;
      int ni, np, fi;
      if (a >= 8 && a <= 15) begin
         for (int j = 0; j < 8; j++) r[4*j +: 4] = 4'(m_pri[(15 - a) * 8 + j]);
         return r;
      end
      case (a)
         0: r = m_ctrl;
         1: r = 32'(m_mask);
         4: r = m_en[63:32];  5: r = m_en[31:0];
         6: r = m_ty[63:32];  7: r = m_ty[31:0];
         16: begin pick_norm(ni, np);
            r = (ni < 0) ? 32'hFFFF_FFFF : ((32'(ni) << 16) | 32'(np)); end
         17: begin fi = pick_fast(); r = (fi < 0) ? 32'hFFFF_FFFF : 32'(fi); end
         18: r = m_pend[63:32]; 19: r = m_pend[31:0];
         22: r = nv[63:32]; 23: r = nv[31:0];
         24: r = fv[63:32]; 25: r = fv[31:0];
         default: r = 0;
      endcase
      return r;
   endfunction

   function automatic bit m_irq();
      bit [63:0] nv = m_pend & m_en & ~m_ty;
      if (m_mask == 31) return nv != 0;
      for (int i = 0; i < 64; i++) if (nv[i] && m_pri[i] > m_mask) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic m_step(bit rd, bit wr, int a, bit [31:0] wd, bit [63:0] s);
      bit [63:0] np = m_pend;
      int ni, pr, fi;
      pick_norm(ni, pr);
      fi = pick_fast();
      for (int i = 0; i < 64; i++) begin
         if (s[i] && !m_srcq[i]) np[i] = 1'b1;
         else if (!s[i] && m_srcq[i]) np[i] = 1'b0;
      end
      if (wr && a == 20) np[63:32] = wd;
      if (wr && a == 21) np[31:0] = wd;
      if (rd && a == 16 && ni >= 0) np[ni] = 1'b0;
      if (rd && a == 17 && fi >= 0) np[fi] = 1'b0;
      m_pend = np; m_srcq = s;
      if (wr) begin
         case (a)
            0: m_ctrl = wd & 32'h017C_0000;
            1: m_mask = int'(wd & 32'h1F);
            2: if (wd < 64) m_en[wd[5:0]] = 1'b1;
            3: if (wd < 64) m_en[wd[5:0]] = 1'b0;
            4: m_en[63:32] = wd; 5: m_en[31:0] = wd;
            6: m_ty[63:32] = wd; 7: m_ty[31:0] = wd;
            default: if (a >= 8 && a <= 15)
               for (int j = 0; j < 8; j++) m_pri[(15 - a) * 8 + j] = int'(wd[4*j +: 4]);
         endcase
      end
   endtask

   task automatic cyc(bit rd, bit wr, int a, bit [31:0] wd, string tag);
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_addr = 8'(a); bus_wdata = wd; src_i = src_next;
      #0.5;
      chk(tag, $sformatf("rdata@%0d", a), bus_rdata, m_read(a));
      chk(tag, "irq", 32'(irq_o), 32'(m_irq()));
      chk(tag, "fiq", 32'(fiq_o), 32'((m_pend & m_en & m_ty) != 0));
      @(posedge clk);
      m_step(rd, wr, a, wd, src_next);
   endtask

   task automatic rd(int a, string tag);  cyc(1'b1, 1'b0, a, 32'h0, tag); endtask
   task automatic wr(int a, bit [31:0] d, string tag); cyc(1'b0, 1'b1, a, d, tag); endtask

   initial begin
      #(200000 * 4);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) m_pri[i] = 0;
      m_pend = 0; m_en = 0; m_ty = 0; m_srcq = 0; m_ctrl = 0; m_mask = 0; src_next = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state across the map
      for (int a = 0; a < 26; a++) rd(a, "R1");
      rd(8'h40, "R1");
      // R12 control keeps defined bits only
      wr(0, 32'hFFFF_FFFF, "R12"); rd(0, "R12");
      // R5 threshold width
      wr(1, 32'hFFFF_FFFF, "R5"); rd(1, "R5");
      // R3 enable by number
      wr(2, 5, "R3"); wr(2, 40, "R3"); wr(2, 70, "R3");
      rd(4, "R3"); rd(5, "R3");
      wr(3, 5, "R3"); wr(3, 99, "R3"); rd(5, "R3"); rd(2, "R3"); rd(3, "R3");
      wr(5, 32'hFFFF_FFFF, "R3"); wr(4, 32'hFFFF_FFFF, "R3"); rd(4, "R3");
      // R2 source edges
      src_next = 64'h0000_0100_0000_0404;
      rd(19, "R2"); rd(18, "R2"); rd(23, "R11"); rd(22, "R11");
      src_next[2] = 1'b0;
      rd(19, "R2"); rd(19, "R2");
      // R4 type and fast output
      wr(7, 32'h0000_0400, "R4"); rd(25, "R11"); rd(24, "R11"); rd(23, "R11");
      // R6 priorities
      wr(14, 32'h0000_0500, "R6"); wr(13, 32'h0005_0000, "R6");
      wr(12, 32'h0300_0000, "R6"); wr(8, 32'hFEDC_BA98, "R6");
      wr(10, 32'h0000_0002, "R6");
      for (int a = 8; a < 16; a++) rd(a, "R6");
      // R5 threshold gating on source 40 (prio 2)
      wr(1, 31, "R5"); rd(1, "R5");
      wr(1, 1, "R5");  rd(1, "R5");
      wr(1, 2, "R5");  rd(1, "R5");
      src_next[20] = 1'b1; src_next[30] = 1'b1; src_next[10] = 1'b0;
      rd(23, "R5"); rd(23, "R5");
      wr(1, 5, "R5"); rd(1, "R5");
      wr(1, 4, "R5"); rd(1, "R5");
      // R7 normal vector claims: tie 10/20 -> 20; then 30, 40
      src_next[10] = 1'b1; rd(19, "R7");
      wr(7, 0, "R7");
      rd(16, "R7"); rd(16, "R7"); rd(16, "R7"); rd(16, "R7"); rd(16, "R7");
      rd(19, "R7"); rd(18, "R7");
      // R8 fast vector claims
      src_next = 0; rd(19, "R8");
      src_next = 64'h8000_0000_0000_0050; wr(7, 32'h0000_0050, "R8");
      wr(6, 32'h8000_0000, "R8");
      rd(17, "R8"); rd(17, "R8"); rd(17, "R8"); rd(17, "R8"); rd(19, "R8");
      // R9 force, and force beats a same-cycle rising edge on bit 1
      src_next = 0; rd(19, "R9");
      src_next[1] = 1'b1;
      wr(21, 32'h0000_0009, "R9"); rd(19, "R9");
      wr(20, 32'h8000_0001, "R9"); rd(18, "R9");
      // R10 claim beats a same-cycle rising edge on the claimed source
      src_next = 0; wr(21, 32'h0000_0008, "R10"); wr(20, 0, "R10");
      wr(7, 32'h0000_0008, "R10"); rd(24, "R10");
      src_next[3] = 1'b1;
      rd(17, "R10"); rd(19, "R10"); rd(25, "R10");
      // R13 read-only and undefined offsets
      src_next = 64'h0000_0002_0000_0000; rd(18, "R13");
      wr(16, 32'hFFFF_FFFF, "R13"); wr(17, 32'hFFFF_FFFF, "R13");
      wr(18, 32'hFFFF_FFFF, "R13"); wr(19, 32'hFFFF_FFFF, "R13");
      wr(22, 32'hFFFF_FFFF, "R13"); wr(25, 32'hFFFF_FFFF, "R13");
      wr(30, 32'hFFFF_FFFF, "R13"); wr(8'h40, 32'hFFFF_FFFF, "R13");
      rd(18, "R13"); rd(19, "R13"); rd(30, "R13"); rd(8'h40, "R13");
      rd(4, "R13"); rd(7, "R13"); rd(0, "R13");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule